// File: doc/BRIEF.md
# Multi-channel conversion sequencer

This block steps an external single-channel analog-to-digital converter through a programmable window of eight input channels. Software writes a control word holding a first channel, a last channel, a run mode and a trigger source. When the selected trigger fires, the sequencer raises a conversion request and presents a channel number. The converter answers each conversion with a one-cycle done pulse. The sequencer then emits a result strobe tagged with the channel it converted, and moves on to the next channel.

The window runs upward from the first channel to the last channel. When the first channel is numerically above the last, the window wraps from channel 7 to channel 0. In one-pass mode the sequencer stops after the last channel. In continuous mode it restarts at the first channel at once and keeps going until software asks it to stop. A stop request never aborts a conversion that is in flight. That conversion's result is still reported, and the sequencer then goes idle.

Top module: `chan_scan_seq`

## Requirements
- R1: Out of reset, `busy`, `conv_req` and `res_valid` are 0. The control fields reset to first channel 0, last channel 0, one-pass mode and software trigger, so a software start pulse given right after reset converts channel 0 exactly once.
- R2: Control word layout: bits 10:8 hold the first channel, bits 13:11 the last channel, bit 6 the mode and bits 5:4 the trigger source. Channel codes 0..7 select channels 0..7.
- R3: Channels are converted in ascending order from the first channel to the last. When the first is above the last, the order wraps from 7 to 0. For example, first 2 and last 1 gives 2,3,4,5,6,7,0,1.
- R4: When the first and last channels are equal, one pass converts exactly one channel.
- R5: With mode bit 0, each channel of the window is converted once. `busy` then drops and no further result appears until a new trigger.
- R6: With mode bit 1, the window is converted repeatedly. Each new pass begins at the first channel directly after the last channel completes, without a new trigger.
- R7: The trigger source code selects the start event: 0 is the `sw_start` pulse, 1 is the `tmr_uf` pulse and 3 is the external pin. A start event from a source that is not selected has no effect.
- R8: Trigger code 2 is reserved and never starts a run.
- R9: The external pin `ext_trig_n` is active-low and passes through a two-flop synchronizer. Only its falling edge starts a run. A rising edge or a held level does not.
- R10: A start event that arrives while `busy` is 1 is ignored. It neither restarts nor extends the pass.
- R11: A `sw_stop` pulse during a run takes effect when the conversion in flight finishes. That result is still reported and `busy` then clears. Exactly one more result follows the stop.
- R12: A `sw_stop` pulse that coincides with a `conv_done` pulse ends the run on that very conversion, whose result is reported.
- R13: A `sw_stop` pulse while idle has no effect on the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word: first, last, mode, trigger fields |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| tmr_uf | input | 1 | Timer underflow start pulse |
| ext_trig_n | input | 1 | Asynchronous external trigger pin, active-low |
| conv_done | input | 1 | Converter finished the current conversion (one cycle) |
| conv_req | output | 1 | Conversion wanted on `chan_sel` |
| chan_sel | output | 3 | Channel being converted |
| res_valid | output | 1 | One-cycle strobe: a conversion completed |
| res_chan | output | 3 | Channel of the completed conversion |
| busy | output | 1 | A run is in progress |

## Verification
A stop request and the completion of a conversion can land on the same clock edge. In that case the sequencer must both report the finished channel and end the run, without converting one more channel. The bench provokes this with a converter model that, on request, raises `sw_stop` in the very cycle it pulses `conv_done`. It then judges the outcome by requiring exactly one result after the stop was armed, the tagged channel matching the expected sequence, and `busy` low on the following cycle. A second overlap is a start event arriving mid-pass, which the bench fires repeatedly during a full-window pass. It requires the result count to equal exactly one window.

// File: rtl/chan_scan_pkg.sv
`timescale 1ns/1ps
package chan_scan_pkg;

   // control word layout
   localparam int CFG_W      = 16;
   localparam int FIELD_W    = 3;
   localparam int FIRST_LSB  = 8;
   localparam int LAST_LSB   = 11;
   localparam int MODE_BIT   = 6;
   localparam int TRIG_LSB   = 4;

   typedef enum logic [1:0] {
      TRG_SOFT  = 2'd0,
      TRG_TIMER = 2'd1,
      TRG_RSVD  = 2'd2,
      TRG_PIN   = 2'd3
   } trig_src_e;

   typedef enum logic {
      MODE_ONCE = 1'b0,
      MODE_LOOP = 1'b1
   } run_mode_e;

endpackage

// File: rtl/chan_scan_cfg.sv
`timescale 1ns/1ps
module chan_scan_cfg
   import chan_scan_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CH_W-1:0]  first_ch,
   output logic [CH_W-1:0]  last_ch,
   output run_mode_e        mode,
   output trig_src_e        trig_sel
);

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_ch <= '0;
         last_ch  <= '0;
         mode     <= MODE_ONCE;
         trig_sel <= TRG_SOFT;
      end else if (we) begin
         first_ch <= wdata[FIRST_LSB +: CH_W];
         last_ch  <= wdata[LAST_LSB +: CH_W];
         mode     <= run_mode_e'(wdata[MODE_BIT]);
         trig_sel <= trig_src_e'(wdata[TRIG_LSB +: 2]);
      end
   end

endmodule

// File: rtl/chan_scan_trig.sv
`timescale 1ns/1ps
module chan_scan_trig
   import chan_scan_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  trig_src_e trig_sel,
   input  logic      sw_start,
   input  logic      tmr_pulse,
   input  logic      pin_raw,
   output logic      start_pulse
);

   localparam logic IDLE_LVL = PIN_ACTIVE_LOW;
   localparam int   TOP      = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   pin_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LVL}};
         last_q <= IDLE_LVL;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
         last_q <= sync_q[TOP];
      end
   end

   generate
      if (PIN_ACTIVE_LOW) begin : g_fall
         assign pin_edge = last_q & ~sync_q[TOP];
      end else begin : g_rise
         assign pin_edge = ~last_q & sync_q[TOP];
      end
   endgenerate

   always_comb begin
      unique case (trig_sel)
         TRG_SOFT:  start_pulse = sw_start;
         TRG_TIMER: start_pulse = tmr_pulse;
         TRG_PIN:   start_pulse = pin_edge;
         default:   start_pulse = 1'b0;
      endcase
   end

   // R8: reserved code never produces a start
   a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel == TRG_RSVD) |-> !start_pulse);

   // R9: a pin start is a single-cycle event
   a_r9_pin_single: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel == TRG_PIN && start_pulse) |=> (trig_sel != TRG_PIN || !start_pulse));

endmodule

// File: rtl/chan_scan_walk.sv
`timescale 1ns/1ps
module chan_scan_walk
   import chan_scan_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic [CH_W-1:0] first_ch,
   input  logic [CH_W-1:0] last_ch,
   input  run_mode_e       mode,
   input  logic            stop_req,
   input  logic            conv_done,
   output logic            run,
   output logic [CH_W-1:0] chan_sel,
   output logic            res_valid,
   output logic [CH_W-1:0] res_chan
);

   localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

   logic            run_q, stop_q, loop_q;
   logic [CH_W-1:0] cur_q, first_q, last_q;
   logic            at_end, halt;
   logic [CH_W-1:0] next_ch;

   assign at_end  = (cur_q == last_q);
   assign halt    = stop_q | stop_req | (at_end & ~loop_q);
   assign next_ch = (cur_q == TOP_CH) ? '0 : cur_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         stop_q     <= 1'b0;
         loop_q     <= 1'b0;
         cur_q      <= '0;
         first_q    <= '0;
         last_q     <= '0;
         res_valid  <= 1'b0;
         res_chan   <= '0;
      end else begin
         res_valid <= 1'b0;
         if (!run_q) begin
            stop_q <= 1'b0;
            if (launch) begin
               run_q   <= 1'b1;
               cur_q   <= first_ch;
               first_q <= first_ch;
               last_q  <= last_ch;
               loop_q  <= (mode == MODE_LOOP);
            end
         end else begin
            if (stop_req) stop_q <= 1'b1;
            if (conv_done) begin
               res_valid <= 1'b1;
               res_chan  <= cur_q;
               if (halt) run_q <= 1'b0;
               else      cur_q <= at_end ? first_q : next_ch;
            end
         end
      end
   end

   assign run      = run_q;
   assign chan_sel = cur_q;

   // R1: a result strobe only follows a completed conversion
   a_r1_result_from_done: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(conv_done && run_q));

   // R3: mid-window the channel advances by one, wrapping at the top
   a_r3_ascending_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && conv_done && !stop_q && !stop_req && cur_q != last_q) |=>
      (chan_sel == (($past(chan_sel) == TOP_CH) ? '0 : $past(chan_sel) + 1'b1)));

   // R5: one-pass run ends on the last channel
   a_r5_once_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && conv_done && !loop_q && cur_q == last_q) |=> !run_q);

   // R10: without a completion the run and channel hold, whatever triggers do
   a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !conv_done) |=> (run_q && $stable(chan_sel)));

   // R11 / R12: a pending or coincident stop ends the run on that completion
   a_r11_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && conv_done && (stop_q || stop_req)) |=> (!run_q && res_valid));

endmodule

// File: rtl/chan_scan_seq.sv
`timescale 1ns/1ps
module chan_scan_seq
   import chan_scan_pkg::*;
#(
   parameter int NUM_CH         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   input  logic        sw_start,
   input  logic        sw_stop,
   input  logic        tmr_uf,
   input  logic        ext_trig_n,
   input  logic        conv_done,
   output logic        conv_req,
   output logic [2:0]  chan_sel,
   output logic        res_valid,
   output logic [2:0]  res_chan,
   output logic        busy
);

   localparam int CH_W = $clog2(NUM_CH);

   generate
      if (NUM_CH != (1 << FIELD_W)) begin : g_bad_ch
         $error("chan_scan_seq: NUM_CH must match the 3-bit channel fields");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("chan_scan_seq: SYNC_STAGES must be at least 2");
      end
      if (CFG_W != 16) begin : g_bad_cfg
         $error("chan_scan_seq: control word must be 16 bits");
      end
   endgenerate

   logic [CH_W-1:0] first_ch, last_ch;
   run_mode_e       mode;
   trig_src_e       trig_sel;
   logic            launch;
   logic            run;
   logic [CH_W-1:0] cur_ch, done_ch;

   chan_scan_cfg #(.CH_W(CH_W)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .first_ch (first_ch),
      .last_ch  (last_ch),
      .mode     (mode),
      .trig_sel (trig_sel)
   );

   chan_scan_trig #(
      .SYNC_STAGES    (SYNC_STAGES),
      .PIN_ACTIVE_LOW (PIN_ACTIVE_LOW)
   ) i_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_sel    (trig_sel),
      .sw_start    (sw_start),
      .tmr_pulse   (tmr_uf),
      .pin_raw     (ext_trig_n),
      .start_pulse (launch)
   );

   chan_scan_walk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .first_ch  (first_ch),
      .last_ch   (last_ch),
      .mode      (mode),
      .stop_req  (sw_stop),
      .conv_done (conv_done),
      .run       (run),
      .chan_sel  (cur_ch),
      .res_valid (res_valid),
      .res_chan  (done_ch)
   );

   assign busy     = run;
   assign conv_req = run;
   assign chan_sel = cur_ch;
   assign res_chan = done_ch;

   // R13: an idle stop leaves the sequencer idle
   a_r13_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sw_stop && !launch) |=> !busy);

endmodule

// File: tb/test_chan_scan_seq.sv
`timescale 1ns/1ps
module test_chan_scan_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        sw_start = 1'b0;
   logic        tb_stop = 1'b0;
   logic        model_stop = 1'b0;
   logic        sw_stop;
   logic        tmr_uf = 1'b0;
   logic        ext_trig_n = 1'b1;
   logic        conv_done = 1'b0;
   logic        conv_req;
   logic [2:0]  chan_sel;
   logic        res_valid;
   logic [2:0]  res_chan;
   logic        busy;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int obs[$];
   bit stop_on_done = 1'b0;

   assign sw_stop = tb_stop | model_stop;

   always #2 clk = ~clk;

   chan_scan_seq i_chan_scan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .sw_start(sw_start), .sw_stop(sw_stop), .tmr_uf(tmr_uf),
      .ext_trig_n(ext_trig_n), .conv_done(conv_done), .conv_req(conv_req),
      .chan_sel(chan_sel), .res_valid(res_valid), .res_chan(res_chan),
      .busy(busy)
   );

   // converter model: random latency, one-cycle done pulse
   initial begin
      int lat;
      lat = 1;
      forever begin
         @(negedge clk);
         if (conv_done) begin
            conv_done  = 1'b0;
            model_stop = 1'b0;
            lat = int'($urandom_range(0, 3));
         end else if (conv_req && rst_n) begin
            if (lat == 0) begin
               conv_done = 1'b1;
               if (stop_on_done) model_stop = 1'b1;
            end else lat--;
         end
      end
   end

   // result collector, sampled just after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (res_valid) obs.push_back(int'(res_chan));
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int win_len(input int s, input int e);
      return ((e - s + 8) % 8) + 1;
   endfunction

   function automatic int nth_ch(input int s, input int e, input int k);
      return (s + (k % win_len(s, e))) % 8;
   endfunction

   // compare the whole observed list against the expected channel walk
   task automatic chk_seq(input string req, input int s, input int e, input int n);
      int bad;
      int act;
      int exp;
      bad = -1;
      act = 0;
      exp = 0;
      for (int i = 0; i < obs.size(); i++) begin
         if (bad < 0 && obs[i] != nth_ch(s, e, i)) begin
            bad = i; act = obs[i]; exp = nth_ch(s, e, i);
         end
      end
      if (bad >= 0) chk(1'b0, req, act, exp);
      else          chk(obs.size() == n, req, obs.size(), n);
   endtask

   task automatic write_cfg(input int s, input int e, input int m, input int t);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = 16'((e << 11) | (s << 8) | (m << 6) | (t << 4));
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic fire(input int src);
      @(negedge clk);
      if (src == 0) sw_start = 1'b1;
      else if (src == 1) tmr_uf = 1'b1;
      else if (src == 3) ext_trig_n = 1'b0;
      @(negedge clk);
      sw_start = 1'b0;
      tmr_uf   = 1'b0;
      if (src == 3) begin
         repeat (3) @(negedge clk);
         ext_trig_n = 1'b1;
      end
   endtask

   task automatic pulse_stop();
      @(negedge clk);
      tb_stop = 1'b1;
      @(negedge clk);
      tb_stop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic wait_results(input int n);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (obs.size() >= n) break;
      end
   endtask

   task automatic one_pass(input string req, input int s, input int e, input int src);
      obs.delete();
      write_cfg(s, e, 0, src);
      fire(src);
      wait_idle();
      repeat (3) @(negedge clk);
      chk_seq(req, s, e, win_len(s, e));
   endtask

   initial begin
      int k;
      void'($urandom(32'h5eed_c0de));
      repeat (5) @(negedge clk);
      chk(busy == 1'b0 && conv_req == 1'b0 && res_valid == 1'b0, "R1 reset outputs",
          int'({busy, conv_req, res_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: defaults give channel 0, one pass, software trigger
      obs.delete();
      fire(0);
      wait_idle();
      repeat (3) @(negedge clk);
      chk_seq("R1 default config", 0, 0, 1);

      one_pass("R3 wrap 2..1", 2, 1, 0);
      one_pass("R4 single channel 5", 5, 5, 0);
      one_pass("R2 fields 0..3", 0, 3, 0);
      repeat (20) @(negedge clk);
      chk(obs.size() == 4 && !busy, "R5 stays idle after pass", obs.size(), 4);

      // R7: timer selected, other sources ignored
      obs.delete();
      write_cfg(1, 2, 0, 1);
      fire(0);
      fire(3);
      repeat (10) @(negedge clk);
      chk(obs.size() == 0 && !busy, "R7 unselected sources ignored", obs.size(), 0);
      fire(1);
      wait_idle();
      repeat (3) @(negedge clk);
      chk_seq("R7 timer start", 1, 2, 2);

      // R8: reserved code
      obs.delete();
      write_cfg(0, 7, 0, 2);
      fire(0);
      fire(1);
      fire(3);
      repeat (10) @(negedge clk);
      chk(obs.size() == 0 && !busy, "R8 reserved never starts", obs.size(), 0);

      // R9: pin falling edge starts, rising edge does not
      obs.delete();
      write_cfg(6, 6, 0, 3);
      @(negedge clk);
      ext_trig_n = 1'b0;
      repeat (30) @(negedge clk);
      wait_idle();
      repeat (3) @(negedge clk);
      chk_seq("R9 falling edge, held low", 6, 6, 1);
      ext_trig_n = 1'b1;
      repeat (12) @(negedge clk);
      chk(obs.size() == 1 && !busy, "R9 rising edge ignored", obs.size(), 1);

      // R10: starts during a pass ignored
      obs.delete();
      write_cfg(0, 7, 0, 0);
      fire(0);
      repeat (4) begin
         repeat (3) @(negedge clk);
         fire(0);
      end
      wait_idle();
      repeat (3) @(negedge clk);
      chk_seq("R10 mid-pass triggers ignored", 0, 7, 8);

      // R6 / R11: continuous with wrap, then stop
      obs.delete();
      write_cfg(6, 2, 1, 0);
      fire(0);
      wait_results(12);
      chk(busy == 1'b1, "R6 continuous still running", int'(busy), 1);
      @(negedge clk);
      k = obs.size();
      tb_stop = 1'b1;
      @(negedge clk);
      tb_stop = 1'b0;
      wait_idle();
      repeat (20) @(negedge clk);
      chk_seq("R11 stop lets in-flight finish", 6, 2, k + 1);
      chk(!busy && !conv_req, "R11 busy cleared", int'(busy), 0);

      // R13: idle stop has no effect
      obs.delete();
      pulse_stop();
      write_cfg(3, 3, 1, 0);
      fire(0);
      wait_results(4);
      chk(busy == 1'b1 && obs.size() >= 4, "R13 idle stop ignored", obs.size(), 4);
      pulse_stop();
      wait_idle();
      repeat (5) @(negedge clk);

      // R12: stop coincides with done
      obs.delete();
      write_cfg(4, 1, 1, 0);
      fire(0);
      wait_results(3);
      @(posedge clk);
      #1;
      stop_on_done = 1'b1;
      @(negedge clk);
      k = obs.size();
      wait_idle();
      stop_on_done = 1'b0;
      repeat (10) @(negedge clk);
      chk_seq("R12 stop with done", 4, 1, k + 1);
      chk(!busy, "R12 idle after coincident stop", int'(busy), 0);

      // random one-pass runs over all sources
      for (int it = 0; it < 24; it++) begin
         int s;
         int e;
         int src;
         s = int'($urandom_range(0, 7));
         e = int'($urandom_range(0, 7));
         src = int'($urandom_range(0, 2));
         if (src == 2) src = 3;
         one_pass("R3 random window", s, e, src);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule